// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a tag-to-reader reply from a single digitized envelope line, which is the output of a hysteresis comparator. The reply carries no start or stop markers. The caller therefore states the reply length, from 1 up to `MAX_BITS`, at the moment the reader frame ends. That moment is marked by a one-cycle `frame_end` pulse. The block then waits a fixed guard interval and divides the following time into equal bit windows. In each window it counts the transitions of the envelope line. A transition count inside a fixed band decodes as a one. A count close to zero, or a count above the band, decodes as a zero. As a consequence, a tag that answers with all zeros cannot be told apart from no tag being present.

Received bits fill the output word from the least significant end. After the last window the block issues a single valid pulse. With that pulse it presents the raw word and the same word XORed with a keystream. The keystream is supplied on `key_in` together with `frame_end` and is cut to the reply length. The tick rate (`TICK_DIV` clocks per tick), the guard length (495 ticks), the bit window (143 ticks), the band limits (more than 20 and fewer than 60) and the synchronizer depth are all parameters.

Top module: `edge_rx`

## Requirements
- R1: After reset, `rx_busy`, `rx_valid` and `rx_reject` are 0, and `rx_raw` and `rx_plain` are all zeros.
- R2: A bit window decodes as one when its transition count is strictly greater than `EDGE_LO` (20) and strictly less than `EDGE_HI` (60). So 20 and 60 decode as zero, while 21 and 59 decode as one.
- R3: A window with no transitions decodes as zero, and a reply with no transitions at all yields an all-zero `rx_raw`.
- R4: Window k (k = 0 for the first window after the guard) sets bit k of `rx_raw`. Bits at or above the requested length are 0.
- R5: `rx_valid` is a one-cycle pulse. It rises exactly `GUARD_TICKS*TICK_DIV + N*BIT_TICKS*TICK_DIV` clock edges after the edge that accepts `frame_end`, where N is the length. Window boundaries do not drift across a long reply.
- R6: When `rx_valid` is high, `rx_plain` equals `rx_raw` XOR the low N bits of the `key_in` value captured at acceptance.
- R7: If `frame_end` arrives while idle with `bit_count` equal to 0 or greater than `MAX_BITS`, the request is rejected. `rx_reject` pulses on the next edge, `rx_busy` stays 0, no `rx_valid` follows, and `rx_raw` and `rx_plain` keep their values.
- R8: A `frame_end` pulse while `rx_busy` is high is ignored. The current reply's length, key, timing and result are unchanged.
- R9: `rx_busy` is high from the accepting edge until the edge that raises `rx_valid`, and falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | One-cycle pulse marking the end of the reader frame; starts a reception when idle |
| bit_count | input | 7 | Reply length in bits, sampled with `frame_end` |
| env_in | input | 1 | Asynchronous envelope line from the comparator |
| key_in | input | 32 | Keystream bits, sampled with `frame_end` |
| rx_busy | output | 1 | Reception in progress |
| rx_valid | output | 1 | One-cycle pulse: result words are updated |
| rx_raw | output | 32 | Decoded word, first bit in bit 0 |
| rx_plain | output | 32 | Decoded word XOR keystream |
| rx_reject | output | 1 | One-cycle pulse: length request out of range |

## Verification
The hardest situation to reach is a transition count that lands exactly on a band limit. The count must fall cleanly inside one window and must not smear into its neighbour through the synchronizer latency. The bench places a programmed number of toggles, two clocks apart, well inside each window, away from both boundaries. Directed replies then drive the counts 20, 21, 59, 60 and 0. Random replies mix counts near the limits with counts deep inside and deep outside the band, and a long 32-bit reply checks the exact cycle of the valid pulse to expose boundary drift. An in-flight `frame_end` carrying a different length tests the ignore rule.

// File: rtl/edge_rx_pkg.sv
package edge_rx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GUARD = 2'd1,
    PH_BITS  = 2'd2
  } rx_phase_t;
endpackage

// File: rtl/edge_rx_sync.sv
// Synchronizes the envelope line and flags each level change.
module edge_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_p
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign edge_p = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/edge_rx_timer.sv
// Guard and bit-window sequencer; boundaries advance from the previous boundary.
module edge_rx_timer
  import edge_rx_pkg::*;
#(
  parameter int GUARD_CYC = 495,
  parameter int BIT_CYC   = 143,
  parameter int T_W       = 16,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] last_idx,
  output rx_phase_t        phase,
  output logic [IDX_W-1:0] bit_idx,
  output logic             win_end,
  output logic             frame_done
);
  logic [T_W-1:0]   now_t;
  logic [T_W-1:0]   bound;
  logic [IDX_W-1:0] last_q;
  logic             hit;

  assign hit        = (phase != PH_IDLE) && (now_t == bound);
  assign win_end    = hit && (phase == PH_BITS);
  assign frame_done = win_end && (bit_idx == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      now_t   <= '0;
      bound   <= '0;
      bit_idx <= '0;
      last_q  <= '0;
    end else if (start && phase == PH_IDLE) begin
      phase   <= PH_GUARD;
      now_t   <= T_W'(1);
      bound   <= T_W'(GUARD_CYC);
      bit_idx <= '0;
      last_q  <= last_idx;
    end else if (phase != PH_IDLE) begin
      now_t <= now_t + T_W'(1);
      if (hit) begin
        bound <= bound + T_W'(BIT_CYC);
        if (phase == PH_GUARD)     phase   <= PH_BITS;
        else if (frame_done)       phase   <= PH_IDLE;
        else                       bit_idx <= bit_idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/edge_rx_slicer.sv
// Counts transitions per window, decides each bit, assembles the word LSB first.
module edge_rx_slicer #(
  parameter int BIT_CYC  = 143,
  parameter int EDGE_LO  = 20,
  parameter int EDGE_HI  = 60,
  parameter int MAX_BITS = 32,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                counting,
  input  logic                edge_p,
  input  logic                win_end,
  input  logic [IDX_W-1:0]    bit_idx,
  output logic [MAX_BITS-1:0] word_next
);
  localparam int CNT_W = $clog2(BIT_CYC + 2);

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    total;
  logic                one;
  logic [MAX_BITS-1:0] word;

  assign total     = cnt + CNT_W'(edge_p);
  assign one       = (total > CNT_W'(EDGE_LO)) && (total < CNT_W'(EDGE_HI));
  assign word_next = win_end ? (word | (MAX_BITS'(one) << bit_idx)) : word;

  always_ff @(posedge clk) begin
    if (rst || start || !counting || win_end) cnt <= '0;
    else if (edge_p)                          cnt <= total;
  end

  always_ff @(posedge clk) begin
    if (rst || start) word <= '0;
    else              word <= word_next;
  end
endmodule

// File: rtl/edge_rx.sv
module edge_rx
  import edge_rx_pkg::*;
#(
  parameter int TICK_DIV    = 300,
  parameter int BIT_TICKS   = 143,
  parameter int GUARD_TICKS = 495,
  parameter int EDGE_LO     = 20,
  parameter int EDGE_HI     = 60,
  parameter int MAX_BITS    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_BITS + 1) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_end,
  input  logic [LEN_W-1:0]    bit_count,
  input  logic                env_in,
  input  logic [MAX_BITS-1:0] key_in,
  output logic                rx_busy,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_raw,
  output logic [MAX_BITS-1:0] rx_plain,
  output logic                rx_reject
);
  localparam int BIT_CYC   = BIT_TICKS * TICK_DIV;
  localparam int GUARD_CYC = GUARD_TICKS * TICK_DIV;
  localparam int T_W       = $clog2(GUARD_CYC + MAX_BITS * BIT_CYC + 2);
  localparam int IDX_W     = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  function automatic logic [MAX_BITS-1:0] len_mask(input logic [LEN_W-1:0] n);
    logic [MAX_BITS-1:0] m;
    for (int i = 0; i < MAX_BITS; i++) m[i] = (LEN_W'(i) < n);
    return m;
  endfunction

  rx_phase_t           phase;
  logic                idle, len_ok, accept;
  logic                edge_p, win_end, frame_done;
  logic [IDX_W-1:0]    bit_idx;
  logic [MAX_BITS-1:0] word_next, key_q;

  assign idle   = (phase == PH_IDLE);
  assign len_ok = (bit_count != '0) && (bit_count <= LEN_W'(MAX_BITS));
  assign accept = frame_end && idle && len_ok;

  edge_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(env_in), .edge_p(edge_p)
  );

  edge_rx_timer #(
    .GUARD_CYC(GUARD_CYC), .BIT_CYC(BIT_CYC), .T_W(T_W), .IDX_W(IDX_W)
  ) u_timer (
    .clk(clk), .rst(rst), .start(accept),
    .last_idx(IDX_W'(bit_count - LEN_W'(1))),
    .phase(phase), .bit_idx(bit_idx), .win_end(win_end), .frame_done(frame_done)
  );

  edge_rx_slicer #(
    .BIT_CYC(BIT_CYC), .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI),
    .MAX_BITS(MAX_BITS), .IDX_W(IDX_W)
  ) u_slicer (
    .clk(clk), .rst(rst), .start(accept), .counting(phase == PH_BITS),
    .edge_p(edge_p), .win_end(win_end), .bit_idx(bit_idx), .word_next(word_next)
  );

  assign rx_busy = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q     <= '0;
      rx_valid  <= 1'b0;
      rx_raw    <= '0;
      rx_plain  <= '0;
      rx_reject <= 1'b0;
    end else begin
      rx_valid  <= frame_done;
      rx_reject <= frame_end && idle && !len_ok;
      if (accept) key_q <= key_in & len_mask(bit_count);
      if (frame_done) begin
        rx_raw   <= word_next;
        rx_plain <= word_next ^ key_q;
      end
    end
  end
endmodule

// File: rtl/edge_rx_chk.sv
module edge_rx_chk #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_end,
  input logic [LEN_W-1:0]    bit_count,
  input logic                rx_busy,
  input logic                rx_valid,
  input logic [MAX_BITS-1:0] rx_raw,
  input logic [MAX_BITS-1:0] rx_plain,
  input logic                rx_reject
);
  logic [LEN_W-1:0]    len_q;
  logic [MAX_BITS-1:0] hi_mask;

  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else if (frame_end && !rx_busy && bit_count != '0 && bit_count <= LEN_W'(MAX_BITS))
      len_q <= bit_count;
  end

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) hi_mask[i] = (LEN_W'(i) >= len_q);
  end

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r9_busy_ends: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!rx_busy && $past(rx_busy)));
  a_r7_reject_idle: assert property (@(posedge clk) disable iff (rst)
    rx_reject |-> (!rx_busy && !rx_valid));
  a_r7_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    rx_reject |-> ($stable(rx_raw) && $stable(rx_plain)));
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_raw & hi_mask) == '0));
  a_r6_key_len: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (((rx_raw ^ rx_plain) & hi_mask) == '0));
  a_r8_no_reject_busy: assert property (@(posedge clk) disable iff (rst)
    (rx_busy && frame_end) |=> !rx_reject);
endmodule

bind edge_rx edge_rx_chk #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .frame_end(frame_end), .bit_count(bit_count),
  .rx_busy(rx_busy), .rx_valid(rx_valid), .rx_raw(rx_raw),
  .rx_plain(rx_plain), .rx_reject(rx_reject)
);

// File: tb/test_edge_rx.sv
module test_edge_rx;
  localparam int TICK_DIV = 1;
  localparam int BITC     = 143 * TICK_DIV;
  localparam int GUARD    = 495 * TICK_DIV;
  localparam int MAXB     = 32;
  localparam int LW       = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            frame_end = 1'b0;
  logic [LW-1:0]   bit_count = '0;
  logic            env_in = 1'b0;
  logic [MAXB-1:0] key_in = '0;
  logic            rx_busy, rx_valid, rx_reject;
  logic [MAXB-1:0] rx_raw, rx_plain;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cnt_a [MAXB];

  always #2.5 clk = ~clk;

  edge_rx #(.TICK_DIV(TICK_DIV)) i_edge_rx (
    .clk(clk), .rst(rst), .frame_end(frame_end), .bit_count(bit_count),
    .env_in(env_in), .key_in(key_in), .rx_busy(rx_busy), .rx_valid(rx_valid),
    .rx_raw(rx_raw), .rx_plain(rx_plain), .rx_reject(rx_reject)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int n);
    return (n > 20) && (n < 60);
  endfunction

  function automatic logic [MAXB-1:0] exp_word(input int n);
    logic [MAXB-1:0] w = '0;
    for (int k = 0; k < n; k++) w[k] = exp_bit(cnt_a[k]);
    return w;
  endfunction

  // inj_at > 0 pulses frame_end with a different length mid-frame (R8).
  task automatic run_frame(input int n, input logic [MAXB-1:0] key, input int inj_at);
    logic [MAXB-1:0] ew, mask;
    int seen = -1;
    mask = (n >= MAXB) ? '1 : ((MAXB'(1) << n) - MAXB'(1));
    ew = exp_word(n);
    @(negedge clk);
    bit_count = LW'(n); key_in = key; frame_end = 1'b1;
    @(posedge clk);
    for (int c = 1; c <= GUARD + n * BITC + 20; c++) begin
      @(negedge clk);
      frame_end = (inj_at > 0 && c == inj_at);
      if (c == inj_at) begin bit_count = LW'(n == 1 ? 2 : 1); key_in = ~key; end
      if (rx_valid) begin seen = c - 1; break; end
      if (c == GUARD / 2) chk(rx_busy == 1'b1, "R9 busy during guard", rx_busy, 1);
      if (c > GUARD) begin
        int off = c - GUARD - 1;
        int k = off / BITC;
        int o = off % BITC;
        if (k < n && o >= 10 && ((o - 10) % 2) == 0 && ((o - 10) / 2) < cnt_a[k])
          env_in = ~env_in;
      end
    end
    frame_end = 1'b0;
    chk(seen == GUARD + n * BITC, "R5 valid timing", seen, GUARD + n * BITC);
    chk(rx_raw == ew, "R2/R4 raw word", rx_raw, ew);
    chk(rx_plain == (ew ^ (key & mask)), "R6 plain word", rx_plain, ew ^ (key & mask));
    chk(rx_busy == 1'b0, "R9 busy cleared", rx_busy, 0);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R5 single pulse", rx_valid, 0);
  endtask

  task automatic try_reject(input int n);
    logic [MAXB-1:0] r0 = rx_raw;
    @(negedge clk);
    bit_count = LW'(n); key_in = '1; frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk(rx_reject == 1'b1, "R7 reject pulse", rx_reject, 1);
    chk(rx_busy == 1'b0, "R7 stays idle", rx_busy, 0);
    repeat (GUARD + BITC + 5) begin
      @(negedge clk);
      if (rx_valid || rx_busy) break;
    end
    chk(!rx_valid && !rx_busy && rx_raw == r0, "R7 no reception", rx_raw, r0);
  endtask

  function automatic int pick_cnt();
    case ($urandom % 4)
      0: return int'($urandom % 4);
      1: return 15 + int'($urandom % 11);
      2: return 35 + int'($urandom % 16);
      default: return 55 + int'($urandom % 6);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(!rx_busy && !rx_valid && !rx_reject && rx_raw == '0 && rx_plain == '0,
        "R1 reset state", rx_raw, 0);

    // R2 thresholds: 20,21,59,60,0,42
    cnt_a[0] = 20; cnt_a[1] = 21; cnt_a[2] = 59; cnt_a[3] = 60; cnt_a[4] = 0; cnt_a[5] = 42;
    run_frame(6, 32'h0000_002A, 0);
    chk(rx_raw == 32'h26, "R2 band limits", rx_raw, 32'h26);

    // R3 silent reply
    for (int k = 0; k < MAXB; k++) cnt_a[k] = 0;
    run_frame(8, 32'h0000_00C3, 0);
    chk(rx_raw == '0, "R3 all zero", rx_raw, 0);

    // R4 ordering: only first window set
    cnt_a[0] = 42;
    run_frame(5, '0, 0);
    chk(rx_raw == 32'h1, "R4 first bit in LSB", rx_raw, 1);

    // R5 long reply, alternating pattern
    for (int k = 0; k < MAXB; k++) cnt_a[k] = (k % 3 == 0) ? 42 : 2;
    run_frame(32, 32'hDEAD_BEEF, 0);

    // R7 rejects
    try_reject(0);
    try_reject(33);

    // R8 mid-frame frame_end ignored
    for (int k = 0; k < MAXB; k++) cnt_a[k] = pick_cnt();
    run_frame(10, 32'h1234_5678, GUARD + 3 * BITC + 7);

    // random replies
    for (int r = 0; r < 10; r++) begin
      int n = 1 + int'($urandom % MAXB);
      for (int k = 0; k < MAXB; k++) cnt_a[k] = pick_cnt();
      run_frame(n, $urandom, 0);
    end

    // single-bit reply
    cnt_a[0] = 30;
    run_frame(1, 32'hFFFF_FFFF, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule